// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write a byte-wide asynchronous static RAM that has a 17-bit address, a shared data bus, and active-low chip select, write enable and output enable. The host raises `req` with the address, the write data and the direction flag, and holds them until `ack` pulses. The controller then runs one memory access and completes it. For a read, the byte is returned on `rdata` when `ack` pulses.

The memory timing limits are given in nanoseconds and come from a speed-grade parameter (10, 12 or 15 ns cycle). At elaboration they are converted into clock-cycle counts by ceiling division against the clock period. All strobes come from registers, so no decode glitch reaches the memory pins. The data bus is split at the block edge into an output value, an output enable and an input value, and the pad ring joins them. The controller turns its drivers on only inside a write, after the memory has had time to let go of the bus.

With the defaults (4 ns clock, 10 ns grade) the counts are: write pulse 4 cycles, read 3 cycles, minimum cycle 3 cycles.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` and `ack` are 0.
- R2: `mem_oe_n` is 1 in every cycle in which `mem_we_n` is 0, so a write always runs with output enable high.
- R3: In a write, `mem_cs_n` and `mem_we_n` fall on the same clock edge and rise on the same clock edge, which keeps the memory outputs in high impedance for the whole write.
- R4: `mem_we_n` stays low for max(ceil(t_wp/T), ceil(t_rel/T) + ceil(t_ds/T)) cycles. Here T is the clock period, t_wp the write pulse width (7/8/9 ns), t_rel the bus release time and t_ds the data setup time (both 5/6/7 ns for grades 10/12/15).
- R5: `mem_dq_oe` is 1 only in two places: while `mem_we_n` is low after ceil(t_rel/T) cycles have passed, and in the single cycle after `mem_we_n` rises. It is never 1 while the memory may drive the bus.
- R6: Write data on `mem_dq_o` is driven and stable for at least ceil(t_ds/T) cycles before `mem_we_n` rises. It is still driven in the cycle after, and the memory stores the requested byte.
- R7: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for max(ceil(t_aa/T), ceil(t_oe/T)) cycles. Here t_aa is the address access time (equal to the grade's cycle time) and t_oe the output enable access time (5/6/7 ns). `rdata` is captured on the last of these cycles and equals the byte last written at that address, or 0 if the address was never written.
- R8: Successive falling edges of `mem_cs_n` are at least ceil(t_cyc/T) cycles apart.
- R9: `ack` is high for exactly one cycle per request. It comes in the cycle after the access phase (write pulse plus one hold cycle, or the read, padded up to the minimum cycle) ends. `mem_addr` stays constant while `mem_cs_n` is low, and no access starts while `req` is low.
- R10: The cycle counts follow from the grade and the clock period by ceiling division, giving at least one cycle for any non-zero limit. With a 4 ns clock and the 10 ns grade, a write is acknowledged 6 cycles after acceptance and a read 4 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | DATA_W | Host write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data, valid with `ack` of a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W | Value driven onto the memory data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | DATA_W | Value read from the memory data bus |

## Verification
The checker assumes that the host holds `req`, `req_wr`, `req_addr` and `req_wdata` steady from raising `req` until it sees `ack`, and drops `req` in that same cycle. The bench drives every request through one task that works this way, so the properties never see a request change in the middle of an access. The behavioural memory in the bench works on a 1 ns grid and is the only source of `mem_dq_i`. It returns wrong data until the access time has passed, keeps driving for the output-disable time after a read, and records a flag on bus overlap, short setup, short pulse or output enable low during a write. Random addresses are kept to a small window so that reads land on bytes that were written earlier.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE,
      ST_WHOLD,
      ST_READ,
      ST_PAD,
      ST_ACK
   } asram_st_e;

   // ceiling division; a non-zero limit always yields at least one cycle
   function automatic int ns2cyc(input int ns, input int clk_ns);
      if (ns <= 0) return 0;
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int grade_cycle_ns(input int grade);
      return grade;
   endfunction

   function automatic int grade_wp_ns(input int grade);
      return (grade <= 10) ? 7 : (grade <= 12) ? 8 : 9;
   endfunction

   // setup, output-enable access and bus release share the same figure per grade
   function automatic int grade_short_ns(input int grade);
      return (grade <= 10) ? 5 : (grade <= 12) ? 6 : 7;
   endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int N_CYC  = 3,
   parameter int N_RD   = 3,
   parameter int N_REL  = 2,
   parameter int N_WPUL = 4,
   parameter int CW     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic req_wr,
   output logic accept,
   output logic capture,
   output logic ack,
   output logic cs_n,
   output logic we_n,
   output logic oe_n,
   output logic dq_oe
);

   typedef logic [CW-1:0] cnt_t;
   localparam cnt_t C_WEND = cnt_t'(N_WPUL - 1);
   localparam cnt_t C_REND = cnt_t'(N_RD - 1);
   localparam cnt_t C_REL  = cnt_t'(N_REL);
   localparam cnt_t C_CYC  = cnt_t'(N_CYC);

   asram_st_e state, nxt;
   cnt_t      cnt, nxt_cnt;
   cnt_t      cnt_inc;

   assign cnt_inc = cnt + cnt_t'(1);
   assign accept  = (state == ST_IDLE) && req;
   assign capture = (state == ST_READ) && (cnt == C_REND);

   always_comb begin
      nxt     = state;
      nxt_cnt = cnt_inc;
      unique case (state)
         ST_IDLE: begin
            nxt_cnt = '0;
            if (req) nxt = req_wr ? ST_WRITE : ST_READ;
         end
         ST_WRITE: if (cnt == C_WEND) nxt = ST_WHOLD;
         ST_WHOLD: nxt = (cnt_inc >= C_CYC) ? ST_ACK : ST_PAD;
         ST_READ:  if (cnt == C_REND) nxt = (cnt_inc >= C_CYC) ? ST_ACK : ST_PAD;
         ST_PAD:   if (cnt_inc >= C_CYC) nxt = ST_ACK;
         ST_ACK: begin
            nxt     = ST_IDLE;
            nxt_cnt = '0;
         end
         default: begin
            nxt     = ST_IDLE;
            nxt_cnt = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         cs_n  <= 1'b1;
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         dq_oe <= 1'b0;
         ack   <= 1'b0;
      end else begin
         state <= nxt;
         cnt   <= nxt_cnt;
         cs_n  <= !((nxt == ST_WRITE) || (nxt == ST_READ));
         we_n  <= !(nxt == ST_WRITE);
         oe_n  <= !(nxt == ST_READ);
         dq_oe <= ((nxt == ST_WRITE) && (nxt_cnt >= C_REL)) || (nxt == ST_WHOLD);
         ack   <= (nxt == ST_ACK);
      end
   end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
   parameter int AW = 17,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          capture,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] mem_dq_i,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   output logic [DW-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
      end else if (accept) begin
         mem_addr <= req_addr;
         mem_dq_o <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata <= '0;
      else if (capture) rdata <= mem_dq_i;
   end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int CLK_NS = 4,
   parameter int GRADE  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int T_CYC  = grade_cycle_ns(GRADE);
   localparam int T_AA   = grade_cycle_ns(GRADE);
   localparam int T_WP   = grade_wp_ns(GRADE);
   localparam int T_DS   = grade_short_ns(GRADE);
   localparam int T_OE   = grade_short_ns(GRADE);
   localparam int T_REL  = grade_short_ns(GRADE);

   localparam int N_CYC  = ns2cyc(T_CYC, CLK_NS);
   localparam int N_RD   = imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_OE, CLK_NS));
   localparam int N_REL  = ns2cyc(T_REL, CLK_NS);
   localparam int N_DS   = ns2cyc(T_DS, CLK_NS);
   localparam int N_WPUL = imax(ns2cyc(T_WP, CLK_NS), N_REL + N_DS);
   localparam int N_MAX  = imax(imax(N_WPUL + 1, N_RD), N_CYC);
   localparam int CW     = $clog2(N_MAX + 2);

   generate
      if (GRADE != 10 && GRADE != 12 && GRADE != 15) begin : g_bad_grade
         $error("asram_ctrl: GRADE must be 10, 12 or 15");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("asram_ctrl: CLK_NS must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctrl: widths must be positive");
      end
   endgenerate

   logic accept, capture;

   asram_seq #(
      .N_CYC  (N_CYC),
      .N_RD   (N_RD),
      .N_REL  (N_REL),
      .N_WPUL (N_WPUL),
      .CW     (CW)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .req_wr  (req_wr),
      .accept  (accept),
      .capture (capture),
      .ack     (ack),
      .cs_n    (mem_cs_n),
      .we_n    (mem_we_n),
      .oe_n    (mem_oe_n),
      .dq_oe   (mem_dq_oe)
   );

   asram_dpath #(
      .AW (ADDR_W),
      .DW (DATA_W)
   ) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_dq_i  (mem_dq_i),
      .mem_addr  (mem_addr),
      .mem_dq_o  (mem_dq_o),
      .rdata     (rdata)
   );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
   parameter int AW     = 17,
   parameter int DW     = 8,
   parameter int N_CYC  = 3,
   parameter int N_RD   = 3,
   parameter int N_DS   = 2,
   parameter int N_WPUL = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ack,
   input logic [AW-1:0] mem_addr,
   input logic          mem_cs_n,
   input logic          mem_we_n,
   input logic          mem_oe_n,
   input logic [DW-1:0] mem_dq_o,
   input logic          mem_dq_oe
);

   int   wlow_cnt, drv_cnt, rd_cnt, gap_cnt;
   logic cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wlow_cnt <= 0;
         drv_cnt  <= 0;
         rd_cnt   <= 0;
         gap_cnt  <= N_CYC;
         cs_q     <= 1'b1;
      end else begin
         cs_q     <= mem_cs_n;
         wlow_cnt <= mem_we_n ? 0 : wlow_cnt + 1;
         drv_cnt  <= mem_we_n ? 0 : drv_cnt + (mem_dq_oe ? 1 : 0);
         rd_cnt   <= mem_oe_n ? 0 : rd_cnt + 1;
         if (cs_q && !mem_cs_n)  gap_cnt <= 1;
         else if (gap_cnt < N_CYC) gap_cnt <= gap_cnt + 1;
      end
   end

   AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n); // R2
   AST_CS_WE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $fell(mem_cs_n)); // R3
   AST_CS_WE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> $rose(mem_cs_n)); // R3
   AST_WP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (wlow_cnt >= N_WPUL)); // R4
   AST_DRV_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n || $rose(mem_we_n))); // R5
   AST_DRV_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n); // R5
   AST_DS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (drv_cnt >= N_DS)); // R6
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> mem_dq_oe); // R6
   AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o)); // R6
   AST_RD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (rd_cnt >= N_RD)); // R7
   AST_CYC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_cs_n) |-> (gap_cnt >= N_CYC)); // R8
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R9
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9

endmodule

bind asram_ctrl asram_ctrl_chk #(
   .AW     (ADDR_W),
   .DW     (DATA_W),
   .N_CYC  (N_CYC),
   .N_RD   (N_RD),
   .N_DS   (N_DS),
   .N_WPUL (N_WPUL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .mem_addr  (mem_addr),
   .mem_cs_n  (mem_cs_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_o  (mem_dq_o),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

   localparam int CLK    = 4;
   localparam int T_CYC  = 10;
   localparam int T_AA   = 10;
   localparam int T_OE   = 5;
   localparam int T_WP   = 7;
   localparam int T_DS   = 5;
   localparam int T_REL  = 5;
   localparam int T_OHZ  = 5;

   function automatic int cdiv(input int ns);
      return (ns + CLK - 1) / CLK;
   endfunction

   function automatic int exp_wr_lat();
      int a, b;
      a = cdiv(T_WP);
      b = cdiv(T_REL) + cdiv(T_DS);
      return ((a > b) ? a : b) + 2;
   endfunction

   function automatic int exp_rd_lat();
      int a, b;
      a = cdiv(T_AA);
      b = cdiv(T_OE);
      return ((a > b) ? a : b) + 1;
   endfunction

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_wr = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ack;
   logic [7:0]  rdata;
   logic [16:0] mem_addr;
   logic        mem_cs_n, mem_we_n, mem_oe_n;
   logic [7:0]  mem_dq_o;
   logic        mem_dq_oe;
   logic [7:0]  mem_dq_i = '0;

   always #2 clk = ~clk;

   asram_ctrl u_asram_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_wr    (req_wr),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .ack       (ack),
      .rdata     (rdata),
      .mem_addr  (mem_addr),
      .mem_cs_n  (mem_cs_n),
      .mem_we_n  (mem_we_n),
      .mem_oe_n  (mem_oe_n),
      .mem_dq_o  (mem_dq_o),
      .mem_dq_oe (mem_dq_oe),
      .mem_dq_i  (mem_dq_i)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   // behavioural memory on a 1 ns grid, offset half a ns from clock edges
   logic [7:0]  mdl_mem [int];
   logic [7:0]  shd_mem [int];
   bit          f_cont, f_ds, f_wp, f_oe_wr, f_gap;
   int          wr_ns, ds_ns, rd_ns, hz_ns, since_fall;
   bit          wr_was, mdl_drv, cs_prev;
   logic [7:0]  last_d;
   logic [16:0] wr_addr;

   function automatic logic [7:0] mdl_get(input logic [16:0] a);
      return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : 8'h00;
   endfunction

   function automatic logic [7:0] shd_get(input logic [16:0] a);
      return shd_mem.exists(int'(a)) ? shd_mem[int'(a)] : 8'h00;
   endfunction

   task automatic model_tick();
      bit rd_act, wr_act;
      rd_act = !mem_cs_n && mem_we_n && !mem_oe_n;
      wr_act = !mem_cs_n && !mem_we_n;
      since_fall++;
      if (cs_prev && !mem_cs_n) begin
         if (since_fall < T_CYC) f_gap = 1'b1;
         since_fall = 0;
      end
      cs_prev = mem_cs_n;
      if (rd_act) begin
         rd_ns++;
         hz_ns    = T_OHZ;
         mdl_drv  = 1'b1;
         mem_dq_i = (rd_ns >= T_AA) ? mdl_get(mem_addr) : ~mdl_get(mem_addr);
      end else begin
         rd_ns = 0;
         if (hz_ns > 0) hz_ns--;
         mdl_drv = (hz_ns > 0);
      end
      if (mdl_drv && mem_dq_oe) f_cont = 1'b1;
      if (wr_act) begin
         wr_ns++;
         if (!mem_oe_n) f_oe_wr = 1'b1;
         if (mem_dq_oe) begin
            ds_ns  = (ds_ns > 0 && mem_dq_o == last_d) ? ds_ns + 1 : 1;
            last_d = mem_dq_o;
         end else begin
            ds_ns = 0;
         end
         wr_addr = mem_addr;
         wr_was  = 1'b1;
      end else if (wr_was) begin
         if (ds_ns < T_DS) f_ds = 1'b1;
         if (wr_ns < T_WP) f_wp = 1'b1;
         mdl_mem[int'(wr_addr)] = last_d;
         wr_was = 1'b0;
         wr_ns  = 0;
         ds_ns  = 0;
      end
   endtask

   initial begin
      since_fall = 1000;
      cs_prev    = 1'b1;
      #0.5;
      forever begin
         model_tick();
         #1;
      end
   end

   task automatic clear_flags();
      f_cont = 0; f_ds = 0; f_wp = 0; f_oe_wr = 0; f_gap = 0;
   endtask

   task automatic xfer(input bit wr, input logic [16:0] a, input logic [7:0] d);
      int cyc;
      clear_flags();
      @(negedge clk);
      req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!ack && cyc < 100);
      req = 1'b0;
      chk(ack == 1'b1, "R9 ack arrives", int'(ack), 1);
      if (wr) begin
         chk(cyc == exp_wr_lat(), "R10 write ack latency", cyc, exp_wr_lat());
         shd_mem[int'(a)] = d;
      end else begin
         chk(cyc == exp_rd_lat(), "R10 read ack latency", cyc, exp_rd_lat());
         chk(rdata == shd_get(a), "R7 read data", int'(rdata), int'(shd_get(a)));
      end
      @(negedge clk);
      chk(ack == 1'b0, "R9 ack one cycle", int'(ack), 0);
      chk(mem_cs_n && !mem_dq_oe, "R9 idle without req", int'({mem_cs_n, mem_dq_oe}), 2);
      chk(!f_cont, "R5 bus contention", int'(f_cont), 0);
      chk(!f_oe_wr, "R2 output enable low in write", int'(f_oe_wr), 0);
      chk(!f_gap, "R8 cycle spacing", int'(f_gap), 0);
      if (wr) begin
         chk(!f_ds, "R6 data setup", int'(f_ds), 0);
         chk(!f_wp, "R4 write pulse width", int'(f_wp), 0);
         chk(mdl_get(a) == d, "R6 byte stored", int'(mdl_get(a)), int'(d));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
          int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
      chk(!mem_dq_oe && !ack, "R1 driver and ack in reset", int'({mem_dq_oe, ack}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ack, "R1 first cycle after reset",
          int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}), 28);

      // directed corners
      xfer(1'b0, 17'h00123, 8'h00);          // R7 unwritten address reads 0
      xfer(1'b1, 17'h00000, 8'hA5);          // R3 lowest address
      xfer(1'b1, 17'h1FFFF, 8'h5A);          // R3 highest address
      xfer(1'b0, 17'h00000, 8'h00);
      xfer(1'b0, 17'h1FFFF, 8'h00);
      xfer(1'b1, 17'h00040, 8'hFF);          // R6 all ones
      xfer(1'b1, 17'h00040, 8'h00);          // R6 overwrite with zeros
      xfer(1'b0, 17'h00040, 8'h00);
      xfer(1'b1, 17'h00041, 8'h55);
      xfer(1'b1, 17'h00042, 8'hAA);
      xfer(1'b0, 17'h00041, 8'h00);
      xfer(1'b0, 17'h00042, 8'h00);

      // random mix over a small window
      for (int i = 0; i < 160; i++) begin
         logic [16:0] a;
         logic [7:0]  d;
         bit          w;
         a = {($urandom % 2 == 0) ? 5'h00 : 5'h1F, 12'h000} | 17'($urandom % 24);
         d = 8'($urandom);
         w = ($urandom % 2) == 0;
         xfer(w, a, d);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule